// File: doc/BRIEF.md
# Block-Transfer Micro-op Sequencer

This block takes one block-transfer memory instruction and expands it into a stream of micro-operations. The instruction names a base register, a 16-entry register list, and five mode bits. Two of the mode bits (pre/post and up/down) pick one of four addressing modes. One bit selects load or store. One requests a base update. The fifth bit is a privilege marker and must be zero for the instruction to be legal. The instruction is taken on a valid/ready handshake.

After acceptance the block emits one micro-op per cycle on a valid/ready output. The first op copies the base register into a temporary. Next comes one transfer op per selected register, lowest register first, each with the byte offset to apply to that temporary. When the update bit is set, a closing op adds four times the register count to the base register, or subtracts it. The final op of every sequence carries a last flag. Offsets are chosen so that the lowest-numbered register always meets the lowest memory address. Memory access and register-file writes happen elsewhere.

Instruction layout: condition `[31:28]`, pre/post P `[24]`, up/down U `[23]`, privilege marker S `[22]`, base-update W `[21]`, load/store L `[20]`, base register `[19:16]`, register list `[15:0]`.

Top module: `lsm_uop_seq`

## Requirements
- R1: An instruction accepted with S=1 (insn[22]) is illegal. In the cycle after acceptance `illegal_err` is 1 for one cycle, no micro-op is emitted, and `in_ready` stays 1.
- R2: The first micro-op of a legal instruction has kind 0 (base copy), word `{insn[31:16],16'h0000}`, register = base register, offset 0 and sub 0. It is valid in the cycle after acceptance.
- R3: One transfer op follows for each set list bit, in ascending register order. The kind is 1 (load) when L=1 and 2 (store) when L=0, the register field is the list index, and the word is 0.
- R4: With U=1 the transfer offsets are added (sub=0). For the k-th transfer (k from 0), the offset is 4k when P=0 and 4k+4 when P=1.
- R5: With U=0 the transfer offsets are subtracted (sub=1). With N set bits, the k-th offset is 4N-4-4k when P=0 and 4N-4k when P=1.
- R6: When W=1 a closing op of kind 3 follows. It has register = base register, offset 4N and sub = !U. Its word is `cond<<28 | 32'h02400000 | rn<<16 | rn<<12 | 4N`.
- R7: Exactly one op per sequence has `out_last`=1, and it is the final op.
- R8: An empty register list yields only the base copy and, when W=1, a closing op with immediate 0.
- R9: `in_ready` is 1 when idle and is 0 from acceptance until the last op has been taken. It is 1 again in the cycle after that handshake.
- R10: While `out_valid`=1 and `out_ready`=0, the next cycle keeps `out_valid` and every payload field unchanged.
- R11: After reset `in_ready`=1, `out_valid`=0 and `illegal_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle and able to accept |
| in_insn | input | 32 | Instruction word |
| illegal_err | output | 1 | One-cycle pulse for a rejected mode code |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Downstream takes the micro-op |
| out_kind | output | 2 | 0 copy, 1 load, 2 store, 3 base update |
| out_reg | output | 4 | Transfer register, or base register for copy/update |
| out_offset | output | 7 | Byte offset or update immediate |
| out_sub | output | 1 | Offset is subtracted |
| out_last | output | 1 | Final op of the sequence |
| out_word | output | 32 | Encoded word for copy and update ops |

## Verification
All results are registered, so the base-copy op or the error pulse is due one cycle after the accepting edge. Each later op appears one cycle after the handshake that consumed its predecessor, and `in_ready` returns one cycle after the last handshake. The bench drives inputs on the falling edge and samples one time unit later, between edges. It compares each op only in a cycle where it also holds `out_ready` high, so every comparison refers to the op that the following rising edge consumes. Under back-pressure, a held op is captured and compared against what is shown in the next cycle.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef enum logic [1:0] {
        UOP_COPY    = 2'd0,
        UOP_LOAD    = 2'd1,
        UOP_STORE   = 2'd2,
        UOP_BASEUPD = 2'd3
    } uop_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_COPY,
        PH_XFER,
        PH_UPD
    } phase_e;

    localparam int unsigned INSN_W  = 32;
    localparam int unsigned BIT_L   = 20;
    localparam int unsigned BIT_W   = 21;
    localparam int unsigned BIT_S   = 22;
    localparam int unsigned BIT_U   = 23;
    localparam int unsigned BIT_P   = 24;
    localparam int unsigned RN_LO   = 16;
    localparam int unsigned RN_W    = 4;
    localparam logic [31:0] UPD_OPC = 32'h0240_0000;

endpackage

// File: rtl/lsm_mode_decode.sv
module lsm_mode_decode #(
    parameter int unsigned NREG  = 16,
    parameter int unsigned OFF_W = 7
) (
    input  logic [4:0]       mode,     // {P,U,S,W,L}
    input  logic [NREG-1:0]  reg_list,
    output logic             legal,
    output logic             add_dir,
    output logic             is_load,
    output logic             upd_base,
    output logic [OFF_W-1:0] first_off,
    output logic [OFF_W-1:0] span
);
    localparam int unsigned CNT_W = $clog2(NREG + 1);

    logic [CNT_W-1:0] cnt;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < NREG; i++) begin
            cnt = cnt + CNT_W'(reg_list[i]);
        end
    end

    always_comb begin
        legal    = ~mode[2];
        add_dir  = mode[3];
        is_load  = mode[0];
        upd_base = mode[1];
        span     = OFF_W'(cnt) << 2;
        unique case (mode[4:3])
            2'b00:   first_off = span - OFF_W'(4);
            2'b01:   first_off = '0;
            2'b10:   first_off = span;
            default: first_off = OFF_W'(4);
        endcase
    end

endmodule

// File: rtl/lsm_low_bit.sv
module lsm_low_bit #(
    parameter int unsigned NREG  = 16,
    parameter int unsigned IDX_W = 4
) (
    input  logic [NREG-1:0]  mask,
    output logic [IDX_W-1:0] idx,
    output logic [NREG-1:0]  rest
);
    always_comb begin
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (mask[i]) idx = IDX_W'(i);
        end
        rest = mask & (mask - NREG'(1));
    end

endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
    import lsm_pkg::*;
#(
    parameter int unsigned NREG = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [31:0]               in_insn,
    output logic                      illegal_err,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [1:0]                out_kind,
    output logic [$clog2(NREG)-1:0]   out_reg,
    output logic [$clog2(4*NREG+1)-1:0] out_offset,
    output logic                      out_sub,
    output logic                      out_last,
    output logic [31:0]               out_word
);
    localparam int unsigned IDX_W = $clog2(NREG);
    localparam int unsigned OFF_W = $clog2(4 * NREG + 1);
    localparam int unsigned HI_W  = INSN_W - RN_LO;

    typedef struct packed {
        phase_e           phase;
        logic [NREG-1:0]  mask;
        logic [OFF_W-1:0] off;
        logic [OFF_W-1:0] span;
        logic             add_dir;
        logic             is_load;
        logic             upd_base;
        logic [RN_W-1:0]  rn;
        logic [HI_W-1:0]  hi;
        logic             err;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic             dec_legal, dec_add, dec_load, dec_upd;
    logic [OFF_W-1:0] dec_first, dec_span;
    logic [IDX_W-1:0] low_idx;
    logic [NREG-1:0]  low_rest;
    logic             take;

    lsm_mode_decode #(.NREG(NREG), .OFF_W(OFF_W)) u_decode (
        .mode      (in_insn[BIT_P:BIT_L]),
        .reg_list  (in_insn[NREG-1:0]),
        .legal     (dec_legal),
        .add_dir   (dec_add),
        .is_load   (dec_load),
        .upd_base  (dec_upd),
        .first_off (dec_first),
        .span      (dec_span)
    );

    lsm_low_bit #(.NREG(NREG), .IDX_W(IDX_W)) u_low (
        .mask (s_q.mask),
        .idx  (low_idx),
        .rest (low_rest)
    );

    assign in_ready    = (s_q.phase == PH_IDLE);
    assign out_valid   = (s_q.phase != PH_IDLE);
    assign illegal_err = s_q.err;
    assign take        = out_valid && out_ready;

    // Payload of the op currently presented
    always_comb begin
        out_kind   = UOP_COPY;
        out_reg    = IDX_W'(s_q.rn);
        out_offset = '0;
        out_sub    = 1'b0;
        out_last   = 1'b0;
        out_word   = '0;
        unique case (s_q.phase)
            PH_COPY: begin
                out_kind = UOP_COPY;
                out_word = {s_q.hi, {RN_LO{1'b0}}};
                out_last = !s_q.upd_base && (s_q.mask == '0);
            end
            PH_XFER: begin
                out_kind   = s_q.is_load ? UOP_LOAD : UOP_STORE;
                out_reg    = low_idx;
                out_offset = s_q.off;
                out_sub    = !s_q.add_dir;
                out_last   = !s_q.upd_base && (low_rest == '0);
            end
            PH_UPD: begin
                out_kind   = UOP_BASEUPD;
                out_offset = s_q.span;
                out_sub    = !s_q.add_dir;
                out_last   = 1'b1;
                out_word   = {s_q.hi[HI_W-1:HI_W-4], 28'h0}
                           | UPD_OPC
                           | (32'(s_q.rn) << 16)
                           | (32'(s_q.rn) << 12)
                           | 32'(s_q.span);
            end
            default: ;
        endcase
    end

    // Next state
    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (in_valid) begin
                    if (dec_legal) begin
                        s_d.phase    = PH_COPY;
                        s_d.mask     = in_insn[NREG-1:0];
                        s_d.off      = dec_first;
                        s_d.span     = dec_span;
                        s_d.add_dir  = dec_add;
                        s_d.is_load  = dec_load;
                        s_d.upd_base = dec_upd;
                        s_d.rn       = in_insn[RN_LO +: RN_W];
                        s_d.hi       = in_insn[INSN_W-1:RN_LO];
                    end else begin
                        s_d.err = 1'b1;
                    end
                end
            end
            PH_COPY: begin
                if (out_ready) begin
                    if (s_q.mask != '0)   s_d.phase = PH_XFER;
                    else if (s_q.upd_base) s_d.phase = PH_UPD;
                    else                   s_d.phase = PH_IDLE;
                end
            end
            PH_XFER: begin
                if (out_ready) begin
                    s_d.mask = low_rest;
                    s_d.off  = s_q.add_dir ? s_q.off + OFF_W'(4) : s_q.off - OFF_W'(4);
                    if (low_rest != '0)    s_d.phase = PH_XFER;
                    else if (s_q.upd_base) s_d.phase = PH_UPD;
                    else                   s_d.phase = PH_IDLE;
                end
            end
            default: begin
                if (out_ready) s_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    // Checks
    assert_illegal_rejected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_insn[BIT_S]) |=> (illegal_err && !out_valid && in_ready));

    assert_copy_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_insn[BIT_S]) |=> (out_valid && out_kind == UOP_COPY && !in_ready));

    assert_update_is_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == UOP_BASEUPD) |-> out_last);

    assert_release_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && out_last) |=> (in_ready && !out_valid));

    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_reg)
            && $stable(out_offset) && $stable(out_sub) && $stable(out_last) && $stable(out_word)));

    assert_err_no_uop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_err |-> !out_valid);

endmodule

// File: tb/lsm_uop_seq_bench.sv
module lsm_uop_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_insn = '0;
    logic        illegal_err;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [1:0]  out_kind;
    logic [3:0]  out_reg;
    logic [6:0]  out_offset;
    logic        out_sub;
    logic        out_last;
    logic [31:0] out_word;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    lsm_uop_seq u_lsm_uop_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_insn(in_insn), .illegal_err(illegal_err), .out_valid(out_valid),
        .out_ready(out_ready), .out_kind(out_kind), .out_reg(out_reg),
        .out_offset(out_offset), .out_sub(out_sub), .out_last(out_last),
        .out_word(out_word)
    );

    // {cond,100,P,U,S,W,L,rn,list}
    localparam int NVEC = 8;
    localparam logic [31:0] VEC [NVEC] = '{
        32'hE892_0013,   // IA load, no update
        32'hE825_8001,   // DA store, update
        32'hE93D_00F0,   // DB load, update
        32'hE980_FFFF,   // IB store, no update, full list
        32'hE8A7_0000,   // IA store, update, empty list
        32'h392F_4000,   // DB store, update, single register
        32'h19B1_0A5A,   // IB load, update
        32'h0813_8000    // DA load, no update
    };

    // Expected op stream: {kind,reg,off,sub,last,word}
    logic [46:0] exp_op [20];
    string       exp_tag [20];
    int          exp_n;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic build_expected(input logic [31:0] insn);
        bit p = insn[24], u = insn[23], w = insn[21], l = insn[20];
        logic [3:0]  rn = insn[19:16];
        logic [15:0] lst = insn[15:0];
        int n = 0, k = 0, off;
        for (int i = 0; i < 16; i++) n += lst[i];
        exp_n = 0;
        exp_op[0]  = {2'd0, rn, 7'd0, 1'b0, (n == 0 && !w), insn[31:16], 16'h0000};
        exp_tag[0] = (n == 0) ? "R2/R8 copy" : "R2 copy";
        exp_n = 1;
        for (int i = 0; i < 16; i++) begin
            if (lst[i]) begin
                if (u) off = p ? 4*k + 4 : 4*k;
                else   off = p ? 4*n - 4*k : 4*n - 4 - 4*k;
                exp_op[exp_n]  = {(l ? 2'd1 : 2'd2), 4'(i), 7'(off), !u,
                                  (k == n - 1 && !w), 32'h0};
                exp_tag[exp_n] = u ? "R3/R4 transfer" : "R3/R5 transfer";
                exp_n++;
                k++;
            end
        end
        if (w) begin
            exp_op[exp_n]  = {2'd3, rn, 7'(4*n), !u, 1'b1,
                              ({insn[31:28], 28'h0} | 32'h0240_0000 | (32'(rn) << 16)
                               | (32'(rn) << 12) | 32'(4*n))};
            exp_tag[exp_n] = (n == 0) ? "R6/R8 update" : "R6/R7 update";
            exp_n++;
        end
    endtask

    task automatic run_insn(input logic [31:0] insn, input bit bp);
        int idx = 0, cyc = 0;
        bit held = 0;
        bit r;
        logic [46:0] saved = '0;
        logic [46:0] act;
        build_expected(insn);
        @(negedge clk);
        out_ready = 1'b0;
        in_insn   = insn;
        in_valid  = 1'b1;
        #1;
        check(in_ready == 1'b1, "R9 ready before accept", 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        while (idx < exp_n && cyc < 100) begin
            r = bp ? cyc[0] : 1'b1;
            out_ready = r;
            #1;
            act = {out_kind, out_reg, out_offset, out_sub, out_last, out_word};
            if (held) begin
                check(act == saved && out_valid, "R10 held payload", 64'(act), 64'(saved));
                held = 0;
            end
            if (!out_valid) begin
                check(1'b0, "R9 missing op", 64'(out_valid), 64'd1);
                break;
            end
            if (r) begin
                check(act == exp_op[idx] && !in_ready, exp_tag[idx], 64'(act), 64'(exp_op[idx]));
                idx++;
            end else begin
                saved = act;
                held  = 1;
            end
            cyc++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        #1;
        check(in_ready && !out_valid, "R7/R9 idle after last", 64'({in_ready, out_valid}), 64'b10);
    endtask

    task automatic run_illegal(input logic [31:0] insn);
        @(negedge clk);
        out_ready = 1'b1;
        in_insn   = insn;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check(illegal_err && !out_valid && in_ready, "R1 illegal pulse",
              64'({illegal_err, out_valid, in_ready}), 64'b101);
        @(negedge clk);
        #1;
        check(!illegal_err && !out_valid, "R1 pulse one cycle",
              64'({illegal_err, out_valid}), 64'b00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #1;
        check(in_ready == 1'b1, "R11 reset ready", 64'(in_ready), 64'd1);
        check(out_valid == 1'b0, "R11 reset valid", 64'(out_valid), 64'd0);
        check(illegal_err == 1'b0, "R11 reset err", 64'(illegal_err), 64'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            run_insn(VEC[v], v[0]);
        end

        // Corner cases
        run_illegal(32'hE842_0013);   // S set, R1
        run_illegal(32'hE9F2_0001);   // code 0x1F, R1
        run_insn(32'hE8AC_0000, 1'b1); // R8 empty list under back-pressure
        run_insn(32'hE80C_0000, 1'b0); // R8 empty list, no update: copy only, last
        run_insn(32'hE9A4_8001, 1'b1); // IB with update, R10 back-pressure

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule